// File: doc/BRIEF.md
# VPW Line Interface with Normalization-Bit Pulse Generator

This block sits between a variable-pulse-width protocol engine and the transceiver pins of a single-wire vehicle bus. On the receive side it turns the external receive pin into an internal active-high bus level. A configuration bit states whether the transceiver inverts the bus, so both kinds of transceiver can be used. On the transmit side it drives the external transmit pin from the engine's transmit level.

A loopback mode connects the internal transmit level straight to the internal receive line, with no inversion. In this mode the receive pin is not used and the transmit pin is held passive, so the engine can be tested without touching the bus.

The block also produces the active pulse of the normalization bit that opens an in-frame response. The engine gives a one-cycle start strobe and says whether the response carries a CRC. A symbol-set bit decides which of the two responses gets the long pulse and which gets the short one. The pulse length is counted in ticks of a 1 µs timebase enable. A one-cycle done strobe marks the end of the pulse. All internal levels are active-high: 1 is the active bus state and 0 is passive.

Top module: `vpw_line_if`

## Requirements
- R1: While rst_n is low at a clock edge, and after it, until a start is accepted: tx_pin is 0, nb_done is 0 and no pulse is active.
- R2: With cfg_loopback = 0, rx_line equals rx_pin when cfg_rx_invert = 0 and equals the inverse of rx_pin when cfg_rx_invert = 1.
- R3: With cfg_loopback = 1, rx_line equals the transmit drive (tx_level OR the pulse). cfg_rx_invert and rx_pin have no effect on it.
- R4: With cfg_loopback = 1, tx_pin is held at 0 (passive) whatever tx_level or the pulse do.
- R5: With cfg_loopback = 0, tx_pin equals tx_level OR the active pulse.
- R6: With cfg_nb_alt = 0, a start with nb_with_crc = 1 gives a long pulse of LONG_US ticks (default 128). A start with nb_with_crc = 0 gives a short pulse of SHORT_US ticks (default 64).
- R7: With cfg_nb_alt = 1, the mapping is swapped: nb_with_crc = 1 gives the short pulse and nb_with_crc = 0 gives the long pulse.
- R8: An nb_start while idle makes the pulse active from the next cycle. The pulse stays active until it has counted exactly its length in cycles where tick_us is high at a clock edge. Ticks while idle count nothing.
- R9: nb_done is high for exactly one cycle. This is the first cycle in which the pulse is no longer active, after the edge that samples the final tick.
- R10: An nb_start that arrives while a pulse is active is ignored. The running pulse keeps its length, and no second pulse follows.
- R11: The pulse length is fixed when the start is accepted. Changing cfg_nb_alt or nb_with_crc during the pulse does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | 1 µs timebase enable, one cycle per tick |
| cfg_rx_invert | input | 1 | 1: the transceiver inverts the bus on rx_pin |
| cfg_loopback | input | 1 | 1: internal loopback, pins not used |
| cfg_nb_alt | input | 1 | Normalization-bit symbol set select |
| nb_start | input | 1 | One-cycle request to start the normalization pulse |
| nb_with_crc | input | 1 | 1: the response carries a CRC |
| tx_level | input | 1 | Engine transmit level, 1 = active |
| rx_pin | input | 1 | External receive pin (already synchronized) |
| tx_pin | output | 1 | External transmit pin, 1 = active |
| rx_line | output | 1 | Internal receive bus level, 1 = active |
| nb_done | output | 1 | One-cycle strobe at the end of the pulse |

## Verification
The bench drives a random, sparse tick pattern, so a timer that counts clock cycles instead of ticks, or that counts a tick on the start edge, gives the wrong length. It runs pulses for all four combinations of symbol set and CRC select. A swapped or unswapped mapping then shows up as a 64/128 length error. It also sends start requests and flips the configuration in the middle of a pulse. A design that restarts or re-reads its length would stretch or shorten the pulse, or give a second done strobe. In loopback it uses random pin and polarity values: a design that leaks the pin or inverts the looped path gives a wrong rx_line, and one that does not gate the pin lets the pulse reach tx_pin.

// File: rtl/vpw_pkg.sv
// Shared types for the VPW line interface.
package vpw_pkg;
    // Which of the two pulse lengths a normalization bit uses.
    typedef enum logic {
        NB_SHORT = 1'b0,
        NB_LONG  = 1'b1
    } nb_len_e;
endpackage

// File: rtl/vpw_nb_select.sv
// Picks the pulse length for a normalization bit.
// Assumes: symbol set 0 gives the long pulse to a CRC response; set 1 swaps this.
module vpw_nb_select
    import vpw_pkg::*;
(
    input  logic    with_crc,
    input  logic    alt_set,
    output nb_len_e len_sel
);
    // Map the response type and symbol set onto a length.
    always_comb begin
        if (with_crc != alt_set) len_sel = NB_LONG;
        else                     len_sel = NB_SHORT;
    end
endmodule

// File: rtl/vpw_nb_timer.sv
// Times the active pulse of the normalization bit in ticks of the timebase.
// Assumes: tick is a one-cycle enable. A start is accepted only while idle.
module vpw_nb_timer
    import vpw_pkg::*;
#(
    parameter int SHORT_US = 64,
    parameter int LONG_US  = 128,
    localparam int CNT_W   = $clog2(LONG_US + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    start,
    input  nb_len_e len_sel,
    output logic    busy,
    output logic    done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Pulse state: accept a start, count ticks, finish on the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            last <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    cnt  <= '0;
                    last <= (len_sel == NB_LONG) ? CNT_W'(LONG_US - 1)
                                                 : CNT_W'(SHORT_US - 1);
                end
            end else if (tick) begin
                if (cnt == last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vpw_line_mux.sv
// Routes the transmit and receive levels between the engine and the pins.
// Assumes: rx_pin is already synchronized; internal levels are active-high.
module vpw_line_mux (
    input  logic tx_level,
    input  logic nb_busy,
    input  logic loopback,
    input  logic rx_invert,
    input  logic rx_pin,
    output logic tx_pin,
    output logic rx_line
);
    logic tx_drive;

    // Merge the engine level with the normalization pulse.
    always_comb tx_drive = tx_level | nb_busy;

    // Gate the pin to passive in loopback, otherwise pass the drive through.
    always_comb tx_pin = loopback ? 1'b0 : tx_drive;

    // Choose the looped level, or the pin with polarity correction.
    always_comb rx_line = loopback ? tx_drive : (rx_pin ^ rx_invert);
endmodule

// File: rtl/vpw_line_if.sv
// Top of the VPW line interface: polarity, loopback and the normalization pulse.
// Assumes: the bit filter and symbol decoder sit behind rx_line, outside this block.
module vpw_line_if
    import vpw_pkg::*;
#(
    parameter int SHORT_US = 64,
    parameter int LONG_US  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic cfg_rx_invert,
    input  logic cfg_loopback,
    input  logic cfg_nb_alt,
    input  logic nb_start,
    input  logic nb_with_crc,
    input  logic tx_level,
    input  logic rx_pin,
    output logic tx_pin,
    output logic rx_line,
    output logic nb_done
);
    nb_len_e len_sel;
    logic    nb_busy;

    vpw_nb_select u_sel (
        .with_crc (nb_with_crc),
        .alt_set  (cfg_nb_alt),
        .len_sel  (len_sel)
    );

    vpw_nb_timer #(
        .SHORT_US (SHORT_US),
        .LONG_US  (LONG_US)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_us),
        .start   (nb_start),
        .len_sel (len_sel),
        .busy    (nb_busy),
        .done    (nb_done)
    );

    vpw_line_mux u_mux (
        .tx_level  (tx_level),
        .nb_busy   (nb_busy),
        .loopback  (cfg_loopback),
        .rx_invert (cfg_rx_invert),
        .rx_pin    (rx_pin),
        .tx_pin    (tx_pin),
        .rx_line   (rx_line)
    );
endmodule

// File: rtl/vpw_line_if_chk.sv
// Checker for vpw_line_if: watches the pulse length, the done strobe and the pin gating.
// Assumes: attached through bind and sees the timer busy flag of the top.
module vpw_line_if_chk #(
    parameter int SHORT_US = 64,
    parameter int LONG_US  = 128,
    localparam int CW      = $clog2(LONG_US + 1) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic tick_us,
    input logic cfg_loopback,
    input logic cfg_nb_alt,
    input logic nb_start,
    input logic nb_with_crc,
    input logic tx_pin,
    input logic nb_done,
    input logic nb_busy
);
    logic [CW-1:0] seen;
    logic [CW-1:0] want;

    // Independent tick count of the running pulse and its expected length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
            want <= '0;
        end else if (nb_start && !nb_busy) begin
            seen <= '0;
            want <= (nb_with_crc ^ cfg_nb_alt) ? CW'(LONG_US) : CW'(SHORT_US);
        end else if (nb_busy && tick_us) begin
            seen <= seen + 1'b1;
        end
    end

    AST_LOOP_PIN_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_loopback |-> !tx_pin); // R4
    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_start && !nb_busy) |=> nb_busy); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        nb_done |=> !nb_done); // R9
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        nb_done |-> (!nb_busy && $past(nb_busy))); // R9
    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        nb_done |-> (seen == want)); // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_busy && !tick_us) |=> nb_busy); // R10
endmodule

bind vpw_line_if vpw_line_if_chk #(
    .SHORT_US (SHORT_US),
    .LONG_US  (LONG_US)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_us      (tick_us),
    .cfg_loopback (cfg_loopback),
    .cfg_nb_alt   (cfg_nb_alt),
    .nb_start     (nb_start),
    .nb_with_crc  (nb_with_crc),
    .tx_pin       (tx_pin),
    .nb_done      (nb_done),
    .nb_busy      (nb_busy)
);

// File: tb/vpw_line_if_bench.sv
`timescale 1ns/1ps
module vpw_line_if_bench;
    localparam int SHORT_US = 64;
    localparam int LONG_US  = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0, cfg_rx_invert = 1'b0, cfg_loopback = 1'b0, cfg_nb_alt = 1'b0;
    logic nb_start = 1'b0, nb_with_crc = 1'b0, tx_level = 1'b0, rx_pin = 1'b0;
    logic tx_pin, rx_line, nb_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vpw_line_if #(.SHORT_US(SHORT_US), .LONG_US(LONG_US)) u_vpw_line_if (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cfg_rx_invert(cfg_rx_invert),
        .cfg_loopback(cfg_loopback), .cfg_nb_alt(cfg_nb_alt), .nb_start(nb_start),
        .nb_with_crc(nb_with_crc), .tx_level(tx_level), .rx_pin(rx_pin),
        .tx_pin(tx_pin), .rx_line(rx_line), .nb_done(nb_done)
    );

    function automatic int exp_len(input logic crc, input logic alt);
        return (crc ^ alt) ? LONG_US : SHORT_US;
    endfunction

    function automatic logic exp_rx(input logic loop, input logic inv,
                                    input logic pin, input logic drive);
        return loop ? drive : (pin ^ inv);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One normalization pulse, observed through tx_pin or through the loopback.
    task automatic run_pulse(input logic crc, input logic alt, input logic loop,
                             input bit disturb);
        int ticks = 0;
        int want = exp_len(crc, alt);
        logic obs;
        @(negedge clk);
        cfg_loopback = loop; cfg_nb_alt = alt; nb_with_crc = crc; tx_level = 1'b0;
        rx_pin = $urandom_range(0, 1); nb_start = 1'b1; tick_us = $urandom_range(0, 1);
        @(negedge clk);
        nb_start = 1'b0;
        obs = loop ? rx_line : tx_pin;
        check("R8 pulse active after start", obs, 1);
        if (loop) check("R4 pin passive in loopback", tx_pin, 0);
        for (int i = 0; i < 4000; i++) begin
            obs = loop ? rx_line : tx_pin;
            if (!obs) break;
            if (nb_done) check("R9 done during pulse", nb_done, 0);
            if (disturb && i == 20) begin
                nb_start = 1'b1;             // R10: ignored while busy
                cfg_nb_alt = ~alt;           // R11: no effect mid-pulse
                nb_with_crc = $urandom_range(0, 1);
            end else begin
                nb_start = 1'b0;
            end
            tick_us = ($urandom_range(0, 2) != 0);
            if (tick_us) ticks++;
            @(negedge clk);
        end
        nb_start = 1'b0;
        tick_us = 1'b0;
        check(disturb ? "R11 length kept" : (alt ? "R7 swapped length" : "R6 length"),
              ticks, want);
        check("R9 done at end", nb_done, 1);
        @(negedge clk);
        check("R9 done one cycle", nb_done, 0);
        obs = loop ? rx_line : tx_pin;
        check("R10 no second pulse", obs, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1850));
        repeat (3) @(negedge clk);
        check("R1 tx_pin in reset", tx_pin, 0);
        check("R1 nb_done in reset", nb_done, 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick_us = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle tx_pin", tx_pin, 0);
        check("R1 idle nb_done", nb_done, 0);

        // R2 / R5: normal path with random pins and polarity.
        for (int i = 0; i < 40; i++) begin
            cfg_loopback = 1'b0;
            cfg_rx_invert = $urandom_range(0, 1);
            rx_pin = $urandom_range(0, 1);
            tx_level = $urandom_range(0, 1);
            #1;
            check("R2 rx polarity", rx_line, exp_rx(1'b0, cfg_rx_invert, rx_pin, tx_level));
            check("R5 tx_pin follows level", tx_pin, tx_level);
            @(negedge clk);
        end

        // R3 / R4: loopback with random pins and polarity.
        for (int i = 0; i < 40; i++) begin
            cfg_loopback = 1'b1;
            cfg_rx_invert = $urandom_range(0, 1);
            rx_pin = $urandom_range(0, 1);
            tx_level = $urandom_range(0, 1);
            #1;
            check("R3 loopback rx", rx_line, exp_rx(1'b1, cfg_rx_invert, rx_pin, tx_level));
            check("R4 loopback pin", tx_pin, 0);
            @(negedge clk);
        end

        // R6 / R7: all four mappings, directed.
        for (int m = 0; m < 4; m++) run_pulse(m[0], m[1], 1'b0, 1'b0);
        // R10 / R11: disturbances mid-pulse.
        run_pulse(1'b1, 1'b0, 1'b0, 1'b1);
        run_pulse(1'b0, 1'b0, 1'b0, 1'b1);
        // R3 / R4: pulse seen through loopback.
        run_pulse(1'b1, 1'b1, 1'b1, 1'b0);
        // Random pulses.
        for (int i = 0; i < 8; i++)
            run_pulse($urandom_range(0, 1), $urandom_range(0, 1),
                      $urandom_range(0, 1), $urandom_range(0, 1));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule